// File: doc/BRIEF.md
# Flash Strobe Pulse Sequencer

This block drives the strobe pin of an external flash, either a xenon tube or an LED driver. The pulse is aligned to the video timing of an image sensor. Software arms a sequence by writing a 1 to the enable bit of a control word. The block detects the 0-to-1 change of that bit and clears the bit itself on the next cycle. The block then waits for the next frame-start strobe, asserts the pin, and measures the pulse length in line-start strobes.

The control word carries four fields:
- the enable bit;
- a polarity bit;
- a 2-bit mode field;
- a 2-bit xenon width field.

The xenon modes take their width from the 2-bit field. The LED modes take it from a 16-bit line-count input. In the whole-frame LED mode the pulse lasts exactly one frame.

All control and status pins are plain level or pulse signals. The block has no streamed data path, so no valid/ready back-pressure applies. Every flop is reset by a synchronous, active-high reset.

Top module: `strobe_pulse_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block is idle: `strobe_o` is 0 (default polarity is active high), `enable_o` is 0 and `busy_o` is 0. A reset in the middle of a pulse returns the block to that state.
- R2: A write of the control word (`cfg_we_i`) loads the enable bit. Once the bit reads 1 on `enable_o`, hardware clears it in the next cycle, so `enable_o` is high for exactly one cycle. A write that lands in that clearing cycle is discarded.
- R3: A sequence is initiated only by a 0-to-1 change of the enable bit. An enable rise while `busy_o` is high is ignored, and no second sequence follows.
- R4: After initiation, the strobe goes active in the cycle after the first `frame_start_i` pulse. Until then it stays inactive.
- R5: Mode 2'b00 (xenon) uses a width field w, latched at initiation. The strobe stays active through w+1 `line_start_i` pulses and goes inactive in the cycle after the (w+1)-th one.
- R6: Modes 2'b01 and 2'b10 (LED) behave identically. They use `led_width_i`, sampled at initiation, as the line count. A value of 0 is treated as 1.
- R7: Mode 2'b11 keeps the strobe active from the starting frame start until the next `frame_start_i`, regardless of line starts. The strobe is inactive in the cycle after that frame start.
- R8: Polarity bit 1 makes the strobe active high, and 0 makes it active low. A newly written polarity takes effect on the next cycle, in idle as well as during a pulse.
- R9: `busy_o` is high from the cycle after initiation until the strobe returns inactive, including the wait for frame start.
- R10: A `line_start_i` in the same cycle as the frame start that begins the pulse is not counted. A `frame_start_i` during a mode 00, 01 or 10 pulse is ignored, so an LED width may span frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_enable_i | input | 1 | Enable bit value written |
| cfg_polarity_i | input | 1 | Polarity bit written (1 = active high) |
| cfg_mode_i | input | 2 | Mode field written |
| cfg_xenon_width_i | input | 2 | Xenon width field written (lines minus one) |
| led_width_i | input | 16 | LED pulse width in lines |
| frame_start_i | input | 1 | One-cycle frame start strobe |
| line_start_i | input | 1 | One-cycle line start strobe |
| strobe_o | output | 1 | Flash strobe pin |
| enable_o | output | 1 | Enable bit status, self-clearing |
| busy_o | output | 1 | Sequence armed or pulse in progress |

## Verification
The test drives two kinds of same-cycle collision.

The first places an enable rise in the exact cycle where the closing line start ends a pulse. The rise happens while `busy_o` is still high, so it must be dropped, and the following frame must show no pulse.

The second places a line start in the same cycle as the frame start that begins the pulse. That line start must not be counted, so the pulse must still span the full programmed width.

A behavioural model, built from counters and integers, predicts all three outputs every cycle. The test also counts the line starts seen while the strobe is active.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic [1:0] {
    M_XENON = 2'b00,
    M_LED_A = 2'b01,
    M_LED_B = 2'b10,
    M_FRAME = 2'b11
  } strobe_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_PULSE = 2'b10
  } seq_state_e;
endpackage

// File: rtl/strobe_arm.sv
module strobe_arm (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wr_i,
  input  logic en_i,
  output logic start_o,
  output logic en_o
);
  logic en_q, en_d_q;

  assign start_o = en_q & ~en_d_q;
  assign en_o    = en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q   <= 1'b0;
      en_d_q <= 1'b0;
    end else begin
      en_d_q <= en_q;
      if (start_o)   en_q <= 1'b0;
      else if (wr_i) en_q <= en_i;
    end
  end

  // R2: enable status never survives two cycles
  a_r2_enable_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    en_q |=> !en_q);
  // R3: an initiation is never followed immediately by another
  a_r3_single_start: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> !start_o);
endmodule

// File: rtl/strobe_width_sel.sv
module strobe_width_sel #(
  parameter int LINE_W = 16,
  parameter int XW_W   = 2
) (
  input  logic [1:0]        mode_i,
  input  logic [XW_W-1:0]   xw_i,
  input  logic [LINE_W-1:0] led_w_i,
  output logic [LINE_W-1:0] target_o
);
  import strobe_pkg::*;
  localparam logic [LINE_W-1:0] ONE = {{(LINE_W-1){1'b0}}, 1'b1};

  logic [LINE_W-1:0] xw_ext;
  assign xw_ext = {{(LINE_W-XW_W){1'b0}}, xw_i};

  always_comb begin
    unique case (mode_i)
      M_XENON: target_o = xw_ext + ONE;
      M_FRAME: target_o = ONE;
      default: target_o = (led_w_i == '0) ? ONE : led_w_i;
    endcase
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] target_i,
  input  logic              frame_i,
  input  logic              line_i,
  output logic              active_o,
  output logic              busy_o
);
  import strobe_pkg::*;
  localparam logic [LINE_W-1:0] ONE = {{(LINE_W-1){1'b0}}, 1'b1};

  seq_state_e        state_q, state_d;
  logic [1:0]        mode_q, mode_d;
  logic [LINE_W-1:0] tgt_q, tgt_d, cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_ARMED;
        mode_d  = mode_i;
        tgt_d   = target_i;
      end
      ST_ARMED: if (frame_i) begin
        state_d = ST_PULSE;
        cnt_d   = '0;
      end
      ST_PULSE: begin
        if (mode_q == M_FRAME) begin
          if (frame_i) state_d = ST_IDLE;
        end else if (line_i) begin
          if (cnt_q + ONE == tgt_q) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      mode_q  <= 2'b00;
      tgt_q   <= ONE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q == ST_PULSE);
  assign busy_o   = (state_q != ST_IDLE);

  // R3: a start arriving while busy leaves the latched settings untouched
  a_r3_locked_when_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && start_i) |=> ($stable(tgt_q) && $stable(mode_q)));
  // R4: without a frame start the armed wait persists
  a_r4_wait_frame: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_ARMED && !frame_i) |=> (state_q == ST_ARMED));
  // R5: the line count stays below the latched width during a pulse
  a_r5_cnt_below_target: assert property (@(posedge clk_i) disable iff (rst_i)
    active_o |-> (cnt_q < tgt_q));
  // R7: in whole-frame mode line starts cannot end the pulse
  a_r7_frame_mode_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_o && mode_q == M_FRAME && !frame_i) |=> active_o);
endmodule

// File: rtl/strobe_pulse_ctrl.sv
module strobe_pulse_ctrl #(
  parameter int LINE_W = 16,
  parameter int XW_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_we_i,
  input  logic              cfg_enable_i,
  input  logic              cfg_polarity_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [XW_W-1:0]   cfg_xenon_width_i,
  input  logic [LINE_W-1:0] led_width_i,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  output logic              strobe_o,
  output logic              enable_o,
  output logic              busy_o
);
  logic              pol_q;
  logic [1:0]        mode_cfg_q;
  logic [XW_W-1:0]   xw_cfg_q;
  logic              start;
  logic              active;
  logic [LINE_W-1:0] target;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pol_q      <= 1'b1;
      mode_cfg_q <= 2'b00;
      xw_cfg_q   <= '0;
    end else if (cfg_we_i) begin
      pol_q      <= cfg_polarity_i;
      mode_cfg_q <= cfg_mode_i;
      xw_cfg_q   <= cfg_xenon_width_i;
    end
  end

  strobe_arm u_arm (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (cfg_we_i),
    .en_i    (cfg_enable_i),
    .start_o (start),
    .en_o    (enable_o)
  );

  strobe_width_sel #(.LINE_W(LINE_W), .XW_W(XW_W)) u_width (
    .mode_i   (mode_cfg_q),
    .xw_i     (xw_cfg_q),
    .led_w_i  (led_width_i),
    .target_o (target)
  );

  strobe_seq #(.LINE_W(LINE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start),
    .mode_i   (mode_cfg_q),
    .target_i (target),
    .frame_i  (frame_start_i),
    .line_i   (line_start_i),
    .active_o (active),
    .busy_o   (busy_o)
  );

  assign strobe_o = pol_q ? active : ~active;

  // R9: the strobe is only ever active while busy
  a_r9_active_implies_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_o == pol_q) |-> busy_o);
endmodule

// File: tb/strobe_pulse_ctrl_tb_top.sv
module strobe_pulse_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        we, en, pol, fs, ls;
  logic [1:0]  mode, xw;
  logic [15:0] led_w;
  logic        strobe_o, enable_o, busy_o;

  int checks = 0;
  int errors = 0;
  int act_lines = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int m_en, m_ed, m_st, m_pol, m_mode, m_xw, m_lmode, m_tgt, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_pulse_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(we), .cfg_enable_i(en),
    .cfg_polarity_i(pol), .cfg_mode_i(mode), .cfg_xenon_width_i(xw),
    .led_width_i(led_w), .frame_start_i(fs), .line_start_i(ls),
    .strobe_o(strobe_o), .enable_o(enable_o), .busy_o(busy_o)
  );

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int edge_v;
    if (rst) begin
      m_en = 0; m_ed = 0; m_st = 0; m_pol = 1; m_mode = 0; m_xw = 0;
      m_lmode = 0; m_tgt = 1; m_cnt = 0;
    end else begin
      edge_v = (m_en == 1 && m_ed == 0) ? 1 : 0;
      if (m_st == 0) begin
        if (edge_v == 1) begin
          m_lmode = m_mode;
          if (m_mode == 0) m_tgt = m_xw + 1;
          else if (m_mode == 3) m_tgt = 1;
          else m_tgt = (led_w == 0) ? 1 : int'(led_w);
          m_st = 1;
        end
      end else if (m_st == 1) begin
        if (fs) begin m_st = 2; m_cnt = 0; end
      end else begin
        if (m_lmode == 3) begin
          if (fs) m_st = 0;
        end else if (ls) begin
          m_cnt++;
          if (m_cnt >= m_tgt) m_st = 0;
        end
      end
      m_ed = m_en;
      if (edge_v == 1) m_en = 0;
      else if (we) m_en = en;
      if (we) begin m_pol = pol; m_mode = mode; m_xw = xw; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(strobe_o, (m_pol == 1) ? (m_st == 2) : (m_st != 2), "R8 strobe level per cycle");
      check(enable_o, m_en, "R2 enable status per cycle");
      check(busy_o, (m_st != 0), "R9 busy per cycle");
    end
  end

  task automatic drive(input bit w, input bit e, input bit p, input logic [1:0] md,
                       input logic [1:0] x, input bit f, input bit l);
    @(negedge clk);
    we = w; en = e; pol = p; mode = md; xw = x; fs = f; ls = l;
    if (l && strobe_o == m_pol[0]) act_lines++;
  endtask

  task automatic cyc(input bit f, input bit l);
    drive(0, 0, 0, 2'b00, 2'b00, f, l);
  endtask

  task automatic write_cfg(input bit e, input bit p, input logic [1:0] md, input logic [1:0] x);
    drive(1, e, p, md, x, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  task automatic frame(input int nl, input bit coincide);
    cyc(1, coincide);
    for (int i = 0; i < nl; i++) begin cyc(0, 1); cyc(0, 0); cyc(0, 0); end
  endtask

  task automatic do_reset();
    rst = 1; idle(3);
    @(negedge clk); rst = 0; we = 0; fs = 0; ls = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; we = 0; en = 0; pol = 1; mode = 0; xw = 0; fs = 0; ls = 0; led_w = 0;
    idle(3);
    check(strobe_o, 0, "R1 strobe in reset");
    check(busy_o, 0, "R1 busy in reset");
    @(negedge clk); rst = 0;
    cmp_on = 1;
    idle(1);
    check(strobe_o, 0, "R1 strobe after reset");
    check(enable_o, 0, "R1 enable after reset");

    // R5: xenon widths 0..3
    for (int w = 0; w < 4; w++) begin
      write_cfg(1, 1, 2'b00, w[1:0]);
      idle(3);
      check(busy_o, 1, "R9 busy while armed");
      check(strobe_o, 0, "R4 inactive before frame start");
      act_lines = 0;
      frame(6, 0);
      check(act_lines, w + 1, "R5 xenon line count");
      check(busy_o, 0, "R9 idle after pulse");
    end

    // R10: line start with the opening frame start is not counted
    write_cfg(1, 1, 2'b00, 2'b01);
    idle(2);
    act_lines = 0;
    frame(5, 1);
    check(act_lines, 2, "R10 coincident line start not counted");

    // R6: LED modes
    led_w = 16'd5;
    write_cfg(1, 1, 2'b01, 2'b00);
    idle(2);
    led_w = 16'd1;
    act_lines = 0;
    frame(8, 0);
    check(act_lines, 5, "R6 LED width sampled at initiation");
    led_w = 16'd0;
    write_cfg(1, 1, 2'b10, 2'b00);
    idle(2);
    act_lines = 0;
    frame(4, 0);
    check(act_lines, 1, "R6 LED width zero acts as one");
    // R10: LED width spans a frame boundary
    led_w = 16'd7;
    write_cfg(1, 1, 2'b01, 2'b00);
    idle(2);
    act_lines = 0;
    frame(4, 0);
    check(busy_o, 1, "R10 frame start ignored mid pulse");
    frame(4, 0);
    check(act_lines, 7, "R10 LED width across frames");

    // R7: whole-frame mode
    write_cfg(1, 1, 2'b11, 2'b00);
    idle(2);
    act_lines = 0;
    frame(5, 0);
    check(strobe_o, 1, "R7 active through whole frame");
    check(act_lines, 5, "R7 line starts do not end pulse");
    cyc(1, 0);
    cyc(0, 0);
    check(strobe_o, 0, "R7 ends at next frame start");

    // R8: active-low polarity
    write_cfg(0, 0, 2'b00, 2'b00);
    idle(1);
    check(strobe_o, 1, "R8 idle level with active low");
    write_cfg(1, 0, 2'b00, 2'b01);
    idle(2);
    act_lines = 0;
    frame(4, 0);
    check(act_lines, 2, "R8 active-low pulse width");
    write_cfg(0, 1, 2'b00, 2'b00);
    idle(1);
    check(strobe_o, 0, "R8 polarity restored");

    // R3: enable rise while armed is ignored
    write_cfg(1, 1, 2'b00, 2'b11);
    idle(3);
    write_cfg(1, 1, 2'b00, 2'b00);
    idle(3);
    act_lines = 0;
    frame(6, 0);
    check(act_lines, 4, "R3 rise while busy keeps first width");
    act_lines = 0;
    frame(3, 0);
    check(act_lines, 0, "R3 no second sequence");

    // R2: back-to-back writes give one sequence
    write_cfg(1, 1, 2'b00, 2'b00);
    write_cfg(1, 1, 2'b00, 2'b00);
    idle(1);
    check(enable_o, 0, "R2 second write discarded");
    act_lines = 0;
    frame(3, 0);
    check(act_lines, 1, "R2 one pulse");
    act_lines = 0;
    frame(3, 0);
    check(act_lines, 0, "R2 no repeat");

    // R3: enable rise in the cycle the pulse ends
    write_cfg(1, 1, 2'b00, 2'b00);
    idle(2);
    cyc(1, 0);
    cyc(0, 0);
    drive(1, 1, 1, 2'b00, 2'b00, 0, 0);
    cyc(0, 1);
    idle(3);
    check(busy_o, 0, "R3 rise at pulse end ignored");
    act_lines = 0;
    frame(3, 0);
    check(act_lines, 0, "R3 no pulse after collision");

    // R1: reset mid pulse
    write_cfg(1, 1, 2'b01, 2'b00);
    led_w = 16'd9;
    idle(2);
    frame(2, 0);
    check(strobe_o, 1, "R1 pulse running before reset");
    cmp_on = 0;
    do_reset();
    cmp_on = 1;
    idle(1);
    check(strobe_o, 0, "R1 strobe after mid reset");
    check(busy_o, 0, "R1 busy after mid reset");
    frame(3, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule